// File: doc/BRIEF.md
# Bit-Serial Flag Accumulator and Branch Condition Evaluator

This block sits behind a one-bit-wide ALU. Each result arrives as a stream of single bits, least significant first, and a word is complete after `DATA_W` accepted bits. While a word streams in, the block builds the zero, sign and parity flags itself. Sign and parity are refreshed on every bit. The carry flag is computed elsewhere and is captured from an input pin when the last bit of a word is accepted.

Raw opcode bits from the instruction register drive a purely combinational branch test. A two-bit field picks one of the four flags. A sense bit says whether a set or a clear flag satisfies the test. A further bit overrides the test and makes the branch unconditional. The branch-take output is produced for every opcode. Whether the opcode is a jump, call or return is decided by the logic downstream.

The result stream uses a valid/ready handshake. A bit is accepted on any clock edge where both `res_valid` and `res_ready` are high. The block never applies back-pressure: `res_ready` is high whenever reset is released. A producer may therefore leave gaps by lowering `res_valid`, and the block does not stall it.

Top module: `serflag_unit`

## Requirements
- R1: Outside reset `res_ready` is always 1. A bit is accepted on an edge where `res_valid` and `res_ready` are both 1. Every `DATA_W` accepted bits form one word, least significant bit first, and word framing restarts at bit 0 after reset.
- R2: On each accepted bit taken with `upd_en`=1, `flag_sign` becomes that bit. After a complete word it therefore equals result bit 7.
- R3: On the first bit of a word, the zero flag is preset before that bit is applied. Any accepted 1 bit with `upd_en`=1 clears `flag_zero`. After a complete word, `flag_zero` is 1 exactly when all bits were 0.
- R4: `flag_parity` toggles on every accepted 1 bit with `upd_en`=1, starting from a preset of 1 at the first bit. After a complete word it is 1 exactly when the word holds an even number of ones.
- R5: When the final bit of a word is accepted with `upd_en`=1, `flag_carry` takes the value of `carry_in`.
- R6: An accepted bit taken with `upd_en`=0 leaves all four flags unchanged, but it still counts toward word framing.
- R7: Cycles with `res_valid`=0 change neither the flags nor the word framing.
- R8: `opcode[4:3]` selects the tested flag: 00 selects carry, 01 zero, 10 sign, 11 parity. With `opcode[2]`=0, `branch_take` = 1 when the selected flag equals `opcode[5]`.
- R9: When `opcode[2]`=1, `branch_take` is 1 regardless of the flags and of the other opcode bits.
- R10: `branch_take` depends combinationally on the current opcode and the flags, for every opcode value. Reset clears all four flags to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | A result bit is offered |
| res_ready | output | 1 | Block accepts a bit (high outside reset) |
| res_bit | input | 1 | Serial ALU result bit, LSB first |
| upd_en | input | 1 | Flag update enable for accepted bits |
| carry_in | input | 1 | Carry from the external carry circuit |
| opcode | input | OP_W | Raw instruction register bits |
| flag_carry | output | 1 | Carry flag |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_parity | output | 1 | Even parity flag |
| branch_take | output | 1 | Condition satisfied or unconditional |

## Verification
The assertions assume that `upd_en` does not change inside a word. Only then do the end-of-word checks of zero, parity and carry describe a whole byte. The bench drives `upd_en` and `carry_in` once per word and holds them, and inserts random idle gaps only by lowering `res_valid`. The assertions also assume the producer respects the word framing by counting accepted bits. The bench always sends whole words, so the framing never drifts.

// File: rtl/serflag_pkg.sv
package serflag_pkg;

  typedef enum logic [1:0] {
    SEL_CARRY  = 2'b00,
    SEL_ZERO   = 2'b01,
    SEL_SIGN   = 2'b10,
    SEL_PARITY = 2'b11
  } flag_sel_e;

  typedef struct packed {
    logic carry;
    logic zero;
    logic sign;
    logic parity;
  } flags_t;

  // opcode field positions decoded by the condition evaluator
  localparam int unsigned OP_UNCOND_BIT = 2;
  localparam int unsigned OP_SEL_LO     = 3;
  localparam int unsigned OP_SENSE_BIT  = 5;

endpackage

// File: rtl/serflag_beat_ctr.sv
module serflag_beat_ctr #(
  parameter int unsigned DATA_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic beat,
  output logic first_beat,
  output logic last_beat
);
  localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (beat) begin
      idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
    end
  end

  assign first_beat = (idx_q == '0);
  assign last_beat  = (idx_q == LAST_IDX);
endmodule

// File: rtl/serflag_accum.sv
module serflag_accum
  import serflag_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   beat,
  input  logic   upd_en,
  input  logic   first_beat,
  input  logic   last_beat,
  input  logic   bit_in,
  input  logic   carry_in,
  output flags_t flags
);
  flags_t flags_q;
  logic   zero_base;
  logic   par_base;

  // preset values at the start of a word, running values otherwise
  assign zero_base = first_beat ? 1'b1 : flags_q.zero;
  assign par_base  = first_beat ? 1'b1 : flags_q.parity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (beat && upd_en) begin
      flags_q.sign   <= bit_in;
      flags_q.zero   <= zero_base & ~bit_in;
      flags_q.parity <= par_base ^ bit_in;
      if (last_beat) begin
        flags_q.carry <= carry_in;
      end
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/serflag_cond.sv
module serflag_cond
  import serflag_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  input  flags_t          flags,
  output logic            take
);
  flag_sel_e sel;
  logic      picked;

  assign sel = flag_sel_e'(opcode[OP_SEL_LO +: 2]);

  always_comb begin
    unique case (sel)
      SEL_CARRY:  picked = flags.carry;
      SEL_ZERO:   picked = flags.zero;
      SEL_SIGN:   picked = flags.sign;
      default:    picked = flags.parity;
    endcase
  end

  assign take = opcode[OP_UNCOND_BIT] | (picked == opcode[OP_SENSE_BIT]);
endmodule

// File: rtl/serflag_unit.sv
module serflag_unit
  import serflag_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OP_W   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            res_valid,
  output logic            res_ready,
  input  logic            res_bit,
  input  logic            upd_en,
  input  logic            carry_in,
  input  logic [OP_W-1:0] opcode,
  output logic            flag_carry,
  output logic            flag_zero,
  output logic            flag_sign,
  output logic            flag_parity,
  output logic            branch_take
);
  logic   beat;
  logic   first_beat;
  logic   last_beat;
  flags_t flags;

  assign res_ready = rst_n;
  assign beat      = res_valid & res_ready;

  serflag_beat_ctr #(.DATA_W(DATA_W)) ctr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .first_beat (first_beat),
    .last_beat  (last_beat)
  );

  serflag_accum acc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .upd_en     (upd_en),
    .first_beat (first_beat),
    .last_beat  (last_beat),
    .bit_in     (res_bit),
    .carry_in   (carry_in),
    .flags      (flags)
  );

  serflag_cond #(.OP_W(OP_W)) cond_i (
    .opcode (opcode),
    .flags  (flags),
    .take   (branch_take)
  );

  assign flag_carry  = flags.carry;
  assign flag_zero   = flags.zero;
  assign flag_sign   = flags.sign;
  assign flag_parity = flags.parity;
endmodule

// File: rtl/serflag_chk.sv
module serflag_chk #(
  parameter int unsigned OP_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_bit,
  input logic            upd_en,
  input logic            carry_in,
  input logic [OP_W-1:0] opcode,
  input logic            flag_carry,
  input logic            flag_zero,
  input logic            flag_sign,
  input logic            flag_parity,
  input logic            branch_take,
  input logic            first_beat,
  input logic            last_beat
);
  logic acc;
  assign acc = res_valid && res_ready && upd_en;

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_ready);

  // R2
  sign_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (flag_sign == $past(res_bit)));

  // R3
  zero_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && res_bit) |=> !flag_zero);

  // R4
  parity_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !first_beat && res_bit) |=> (flag_parity != $past(flag_parity)));

  // R5
  carry_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && last_beat) |=> (flag_carry == $past(carry_in)));

  // R6
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> ($stable(flag_carry) && $stable(flag_zero)
              && $stable(flag_sign) && $stable(flag_parity)));

  // R9
  uncond_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    opcode[2] |-> branch_take);
endmodule

bind serflag_unit serflag_chk #(.OP_W(OP_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_bit     (res_bit),
  .upd_en      (upd_en),
  .carry_in    (carry_in),
  .opcode      (opcode),
  .flag_carry  (flag_carry),
  .flag_zero   (flag_zero),
  .flag_sign   (flag_sign),
  .flag_parity (flag_parity),
  .branch_take (branch_take),
  .first_beat  (first_beat),
  .last_beat   (last_beat)
);

// File: tb/serflag_unit_tb_top.sv
module serflag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       res_valid = 1'b0;
  logic       res_ready;
  logic       res_bit = 1'b0;
  logic       upd_en = 1'b0;
  logic       carry_in = 1'b0;
  logic [7:0] opcode = 8'h00;
  logic       flag_carry, flag_zero, flag_sign, flag_parity, branch_take;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // expected flags {carry, zero, sign, parity}
  logic [3:0] exp_f = 4'b0000;

  always #2 clk = ~clk;

  serflag_unit dut_i (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_bit(res_bit), .upd_en(upd_en), .carry_in(carry_in), .opcode(opcode),
    .flag_carry(flag_carry), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_parity(flag_parity), .branch_take(branch_take)
  );

  function automatic logic [3:0] ref_flags(logic [7:0] b, logic c);
    return {c, (b == 8'h00), b[7], ~(^b)};
  endfunction

  function automatic logic ref_take(logic [7:0] op, logic [3:0] f);
    logic pick;
    case (op[4:3])
      2'b00:   pick = f[3];
      2'b01:   pick = f[2];
      2'b10:   pick = f[1];
      default: pick = f[0];
    endcase
    return op[2] | (pick == op[5]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_flags(string req);
    chk(req, {28'd0, flag_carry, flag_zero, flag_sign, flag_parity}, {28'd0, exp_f});
  endtask

  // sweep select, sense and unconditional bits with random remaining bits
  task automatic sweep_take();
    for (int k = 0; k < 16; k++) begin
      logic [7:0] op;
      op = 8'($urandom);
      op[5:2] = 4'(k);
      opcode = op;
      #1;
      chk(op[2] ? "R9 uncond" : "R8 cond", {31'd0, branch_take},
          {31'd0, ref_take(op, exp_f)});
    end
  endtask

  // drive at negedge, sample at next negedge
  task automatic send_word(logic [7:0] b, logic en, logic c, bit gaps);
    upd_en = en;
    carry_in = c;
    for (int i = 0; i < 8; i++) begin
      if (gaps) begin
        int n;
        n = $urandom_range(0, 2);
        for (int g = 0; g < n; g++) begin
          res_valid = 1'b0;
          res_bit = 1'($urandom);
          @(negedge clk);
        end
      end
      res_valid = 1'b1;
      res_bit = b[i];
      @(negedge clk);
      if (en) chk("R2 sign per bit", {31'd0, flag_sign}, {31'd0, b[i]});
    end
    res_valid = 1'b0;
    if (en) exp_f = ref_flags(b, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    check_flags("R10 reset flags");
    chk("R1 ready in reset", {31'd0, res_ready}, 32'd0);
    opcode = 8'h00; #1;
    chk("R10 reset take", {31'd0, branch_take}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", {31'd0, res_ready}, 32'd1);

    // directed corners
    send_word(8'h00, 1'b1, 1'b1, 1'b0); @(negedge clk);
    check_flags("R3 zero byte"); sweep_take();
    send_word(8'h80, 1'b1, 1'b0, 1'b0); @(negedge clk);
    check_flags("R2 msb only"); sweep_take();
    send_word(8'h01, 1'b1, 1'b1, 1'b1); @(negedge clk);
    check_flags("R3 lsb only"); sweep_take();
    send_word(8'hFF, 1'b1, 1'b0, 1'b0); @(negedge clk);
    check_flags("R4 all ones"); sweep_take();
    send_word(8'h07, 1'b1, 1'b1, 1'b0); @(negedge clk);
    check_flags("R4 odd parity"); sweep_take();

    // R6 enable low word: flags hold
    send_word(8'h00, 1'b0, 1'b0, 1'b1); @(negedge clk);
    check_flags("R6 hold when disabled");

    // R7 idle cycles with toggling bit
    res_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      res_bit = 1'($urandom);
      carry_in = ~carry_in;
      @(negedge clk);
    end
    check_flags("R7 idle no change");
    send_word(8'h5A, 1'b1, 1'b1, 1'b0); @(negedge clk);
    check_flags("R1 framing after idle"); sweep_take();

    // random words
    for (int w = 0; w < 300; w++) begin
      logic [7:0] b;
      logic en, c;
      b = 8'($urandom);
      en = ($urandom_range(0, 4) != 0);
      c = 1'($urandom);
      send_word(b, en, c, 1'($urandom));
      @(negedge clk);
      check_flags(en ? "R5 random word flags" : "R6 random hold");
      sweep_take();
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule